// File: doc/BRIEF.md
# SD/MMC Command-Line Frame Transceiver

This block drives and listens to the single-bit command line of an SD or MMC card interface. When the host side asks for it, the block builds a 48-bit command frame from a 6-bit command index and a 32-bit argument. It appends a CRC7 that it computes itself. It then shifts the frame out most significant bit first, one bit on each clock where the card-clock enable is high.

If the command expects an answer, the block stops driving the line and waits a bounded number of enabled clocks for a start bit. It then collects the 48-bit response and reports the returned index field, the 32-bit payload and two status flags, one for the index and one for the CRC and framing. A timeout flag is raised when no start bit arrives in time.

A second checking mode covers operating-condition replies. In those replies the index and CRC fields are all-ones patterns, not an echo and a real checksum.

The controller is a five-state machine. The states are:
- `ST_IDLE`: the line is released and the block is ready.
- `ST_SEND`: a frame is being shifted out.
- `ST_WAIT`: the block searches for a start bit.
- `ST_RECV`: a response is being shifted in.
- `ST_DONE`: a single-cycle completion.

The transitions are:
- *accept*: IDLE→SEND, when `start` is seen while idle.
- *stop-bit sent*: SEND→WAIT when a response is expected, or SEND→DONE when it is not.
- *start-bit found*: WAIT→RECV.
- *window expired*: WAIT→DONE.
- *stop-bit received*: RECV→DONE.
- *complete*: DONE→IDLE.

Top module: `sdcmd_xcvr`

## Requirements
- R1: A sent frame occupies exactly 48 enabled bit periods with `cmd_oe` high. Sent MSB first, it holds: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument, the 7-bit CRC and a 1 stop bit. In the 48-bit vector, with bit 47 sent first, the argument sits at bits 39..8 and the CRC at bits 7..1.
- R2: The CRC is CRC7 with generator x^7+x^3+1 and a zero initial value, taken over the first 40 frame bits. Index 0 with argument 0 gives 0x4A, and index 8 with argument 0x1AA gives 0x43.
- R3: Argument bit 31 (frame bit 39) is sent exactly as given. It has no special meaning on transmit.
- R4: After reset and between frames: `cmd_oe`=0, `cmd_out`=1, `busy`=0, `done`=0, and all three flags are 0.
- R5: `start` is accepted only while `busy` is 0. A `start` pulse while busy changes neither the frame on the line nor the number of completions.
- R6: The line advances only on clocks with `clk_en` high. While `clk_en` is low, `cmd_out` holds its value.
- R7: With `resp_expect`=0, `done` pulses for one clock in the cycle right after the stop-bit period, and no flag is set.
- R8: After a response, `resp_index` shows received frame bits 45..40 and `resp_arg` shows bits 39..8.
- R9: In normal mode (`resp_r3`=0), `idx_err` is set when the returned index differs from the index sent. `crc_err` is set when the received CRC differs from the CRC7 of the first 40 received bits, when the direction bit is 1, or when the stop bit is 0.
- R10: In all-ones mode (`resp_r3`=1), `idx_err` is set when the index field is not 6'h3F, and `crc_err` is set when the CRC field is not 7'h7F (or the framing is bad as in R9).
- R11: The start bit is accepted if it appears within the first `wait_limit` enabled samples after the line is released (a limit of 0 acts as 1). Otherwise `timeout` is set, `done` pulses, and `idx_err` and `crc_err` stay 0.
- R12: Results and flags hold until the next accepted command, which clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Card-clock enable; one line bit per high cycle |
| start | input | 1 | Request to send a command |
| cmd_index | input | 6 | Command index to send |
| cmd_arg | input | 32 | Command argument to send |
| resp_expect | input | 1 | A response is expected after the command |
| resp_r3 | input | 1 | Check the response in all-ones mode |
| wait_limit | input | 7 | Start-bit search window in enabled clocks |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| resp_index | output | 6 | Received index/check field |
| resp_arg | output | 32 | Received payload |
| idx_err | output | 1 | Index field check failed |
| crc_err | output | 1 | CRC or framing check failed |
| timeout | output | 1 | No start bit within the window |
| cmd_out | output | 1 | Value driven on the command line |
| cmd_oe | output | 1 | Drive enable for the command line |
| cmd_in | input | 1 | Value sampled from the command line |

## Verification
The assertions check on every cycle that:
- the first driven bit is low and the stop bit is high;
- the line holds while the enable is low;
- a `start` pulse during a transfer leaves the latched command untouched;
- `done` never lasts two cycles;
- a timeout only comes out of the search state and never comes with another flag;
- results stay frozen while idle.

Only the bench scenarios can show that the whole frame carries the right CRC values and bit order, and that index and CRC mismatches are told apart in each checking mode. The scenarios also show the exact edge of the start-bit window and the clearing of stale flags by a new command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int IDX_W   = 6;
    localparam int ARG_W   = 32;
    localparam int CRC_W   = 7;
    localparam int BODY_W  = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = BODY_W + CRC_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W);

    // generator x^7 + x^3 + 1 without the top term
    localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_DONE
    } xcvr_state_t;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] cur,
                                                   input logic bit_in);
        logic             fb;
        logic [CRC_W-1:0] nxt;
        fb  = bit_in ^ cur[CRC_W-1];
        nxt = {cur[CRC_W-2:0], 1'b0};
        if (fb) nxt = nxt ^ CRC_TAPS;
        return nxt;
    endfunction

    function automatic logic [CRC_W-1:0] crc7_body(input logic [BODY_W-1:0] body);
        logic [CRC_W-1:0] acc;
        acc = '0;
        for (int i = BODY_W - 1; i >= 0; i--) begin
            acc = crc7_step(acc, body[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clear) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc7_step(crc, din);
        end
    end

endmodule

// File: rtl/sdcmd_shreg.sv
module sdcmd_shreg #(
    parameter int W = 47
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/sdcmd_xcvr.sv
module sdcmd_xcvr
    import sdcmd_pkg::*;
#(
    parameter int WAIT_MAX = 64,
    localparam int WAIT_W  = $clog2(WAIT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              resp_expect,
    input  logic              resp_r3,
    input  logic [WAIT_W-1:0] wait_limit,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  resp_index,
    output logic [ARG_W-1:0]  resp_arg,
    output logic              idx_err,
    output logic              crc_err,
    output logic              timeout,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in
);

    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(BODY_W - 1);
    localparam int               RX_W      = FRAME_W - 1;

    xcvr_state_t state, state_nx;

    logic [CNT_W-1:0]   bit_cnt;
    logic [WAIT_W-1:0]  wait_cnt;
    logic [WAIT_W-1:0]  wait_lim_q;
    logic [WAIT_W:0]    wait_next;
    logic               win_end;
    logic [FRAME_W-1:0] tx_q;
    logic [IDX_W-1:0]   cmd_idx_q;
    logic               r3_q;
    logic               expect_q;
    logic               timeout_q;
    logic               got_resp_q;
    logic               accept;
    logic [RX_W-1:0]    rx_q;
    logic [CRC_W-1:0]   rx_crc_calc;

    assign accept    = (state == ST_IDLE) && start;
    assign wait_next = {1'b0, wait_cnt} + 1'b1;
    assign win_end   = wait_next >= {1'b0, wait_lim_q};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SEND;                       // accept
            ST_SEND: if (clk_en && bit_cnt == LAST_BIT)
                         state_nx = expect_q ? ST_WAIT : ST_DONE;         // stop-bit sent
            ST_WAIT: if (clk_en) begin
                         if (!cmd_in)      state_nx = ST_RECV;           // start-bit found
                         else if (win_end) state_nx = ST_DONE;           // window expired
                     end
            ST_RECV: if (clk_en && bit_cnt == LAST_BIT) state_nx = ST_DONE; // stop-bit received
            ST_DONE: state_nx = ST_IDLE;                                  // complete
            default: state_nx = ST_IDLE;
        endcase
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            wait_cnt   <= '0;
            wait_lim_q <= '0;
            tx_q       <= '1;
            cmd_idx_q  <= '0;
            r3_q       <= 1'b0;
            expect_q   <= 1'b0;
            timeout_q  <= 1'b0;
            got_resp_q <= 1'b0;
        end else if (accept) begin
            bit_cnt    <= '0;
            wait_cnt   <= '0;
            wait_lim_q <= wait_limit;
            tx_q       <= {1'b0, 1'b1, cmd_index, cmd_arg,
                           crc7_body({1'b0, 1'b1, cmd_index, cmd_arg}), 1'b1};
            cmd_idx_q  <= cmd_index;
            r3_q       <= resp_r3;
            expect_q   <= resp_expect;
            timeout_q  <= 1'b0;
            got_resp_q <= 1'b0;
        end else if (clk_en) begin
            case (state)
                ST_SEND: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_q    <= {tx_q[FRAME_W-2:0], 1'b1};
                    end
                end
                ST_WAIT: begin
                    if (!cmd_in)      bit_cnt   <= CNT_W'(1);
                    else if (win_end) timeout_q <= 1'b1;
                    else              wait_cnt  <= wait_cnt + 1'b1;
                end
                ST_RECV: begin
                    if (bit_cnt == LAST_BIT) got_resp_q <= 1'b1;
                    else                     bit_cnt    <= bit_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    sdcmd_shreg #(.W(RX_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (state == ST_RECV && clk_en),
        .sin   (cmd_in),
        .q     (rx_q)
    );

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .en    (state == ST_RECV && clk_en && bit_cnt <= BODY_LAST),
        .din   (cmd_in),
        .crc   (rx_crc_calc)
    );

    // received field views
    logic               f_dir, f_stop;
    logic [IDX_W-1:0]   f_idx;
    logic [ARG_W-1:0]   f_arg;
    logic [CRC_W-1:0]   f_crc;
    assign f_dir  = rx_q[RX_W-1];
    assign f_idx  = rx_q[RX_W-2 -: IDX_W];
    assign f_arg  = rx_q[RX_W-2-IDX_W -: ARG_W];
    assign f_crc  = rx_q[CRC_W:1];
    assign f_stop = rx_q[0];

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        cmd_oe     = (state == ST_SEND);
        cmd_out    = cmd_oe ? tx_q[FRAME_W-1] : 1'b1;
        resp_index = f_idx;
        resp_arg   = f_arg;
        timeout    = timeout_q;
        idx_err    = got_resp_q && (r3_q ? (f_idx != '1) : (f_idx != cmd_idx_q));
        crc_err    = got_resp_q &&
                     ((r3_q ? (f_crc != '1) : (f_crc != rx_crc_calc)) || f_dir || !f_stop);
    end

    // ---------------- assertions ----------------
    a_r1_first_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    a_r1_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && bit_cnt == LAST_BIT) |-> cmd_out);

    a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (cmd_idx_q == $past(cmd_idx_q)));

    a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !clk_en) |=> $stable(cmd_out));

    a_r7_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_timeout_from_search: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(state) == ST_WAIT));

    a_r11_timeout_alone: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !(idx_err || crc_err));

    a_r12_results_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(resp_arg) && $stable(idx_err) && $stable(crc_err)));

endmodule

// File: tb/sdcmd_xcvr_bench.sv
module sdcmd_xcvr_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        resp_expect = 1'b0;
    logic        resp_r3 = 1'b0;
    logic [6:0]  wait_limit = 7'd16;
    logic        cmd_in = 1'b1;
    logic        busy, done, idx_err, crc_err, timeout, cmd_out, cmd_oe;
    logic [5:0]  resp_index;
    logic [31:0] resp_arg;

    sdcmd_xcvr u_sdcmd_xcvr (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .resp_expect(resp_expect),
        .resp_r3(resp_r3), .wait_limit(wait_limit), .busy(busy), .done(done),
        .resp_index(resp_index), .resp_arg(resp_arg), .idx_err(idx_err),
        .crc_err(crc_err), .timeout(timeout), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .cmd_in(cmd_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int en_div = 1;
    int en_phase = 0;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            en_phase = (en_phase + 1) % en_div;
            clk_en   = (en_phase == 0);
        end
    end

    // line monitor
    logic [47:0] cap;
    int  cap_n = 0, done_n = 0, glitch_n = 0;
    logic last_oe = 1'b0, last_out = 1'b1, last_en = 1'b0;
    always @(negedge clk) begin
        if (cmd_oe && clk_en) begin
            if (cap_n < 48) cap[47 - cap_n] = cmd_out;
            cap_n++;
        end
        if (cmd_oe && last_oe && !last_en && cmd_out != last_out) glitch_n++;
        if (done) done_n++;
        last_oe  = cmd_oe;
        last_out = cmd_out;
        last_en  = clk_en;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_b(input logic [39:0] m);
        logic [46:0] d;
        d = {m, 7'b0};
        for (int i = 46; i >= 7; i--) begin
            if (d[i]) d[i -: 8] = d[i -: 8] ^ 8'h89;
        end
        return d[6:0];
    endfunction

    function automatic logic [47:0] frame_host(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b01, idx, arg, crc_b({2'b01, idx, arg}), 1'b1};
    endfunction

    function automatic logic [47:0] frame_dev(input logic [5:0] idx, input logic [31:0] arg);
        return {2'b00, idx, arg, crc_b({2'b00, idx, arg}), 1'b1};
    endfunction

    function automatic logic [47:0] frame_r3(input logic [31:0] arg);
        return {2'b00, 6'h3F, arg, 7'h7F, 1'b1};
    endfunction

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg,
                         input logic exp, input logic r3, input logic [6:0] lim);
        @(negedge clk);
        #1;
        cap_n = 0; done_n = 0; glitch_n = 0;
        cmd_index = idx; cmd_arg = arg; resp_expect = exp; resp_r3 = r3;
        wait_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_tx_end();
        int g = 0;
        while (cmd_oe && g < 5000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic wait_en();
        do @(posedge clk); while (!clk_en);
        #1;
    endtask

    task automatic reply(input int gap, input logic [47:0] f, input logic send_frame);
        for (int g = 0; g < gap; g++) begin
            cmd_in = 1'b1;
            wait_en();
        end
        if (send_frame) begin
            for (int i = 47; i >= 0; i--) begin
                cmd_in = f[i];
                wait_en();
            end
        end
        cmd_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_done(output int lag);
        lag = 0;
        while (!done && lag < 2000) begin
            @(negedge clk);
            lag++;
        end
    endtask

    task automatic t_reset();
        chk("R4 busy after reset", busy, 0);
        chk("R4 oe after reset", cmd_oe, 0);
        chk("R4 line idle high", cmd_out, 1);
        chk("R4 done after reset", done, 0);
        chk("R4 flags after reset", {idx_err, crc_err, timeout}, 0);
    endtask

    task automatic t_no_resp(input logic [5:0] idx, input logic [31:0] arg, input logic [6:0] crc_known);
        int lag;
        issue(idx, arg, 1'b0, 1'b0, 7'd16);
        wait_tx_end();
        wait_done(lag);
        chk("R1 bit count", cap_n, 48);
        chk("R1 frame bits", cap, frame_host(idx, arg));
        chk("R2 known crc", cap[7:1], crc_known);
        chk("R7 done right after stop", lag, 0);
        chk("R7 no flags", {idx_err, crc_err, timeout}, 0);
        @(negedge clk);
        chk("R4 idle after frame", {busy, cmd_oe, cmd_out}, 3'b001);
    endtask

    task automatic t_busy_bit();
        int lag;
        issue(6'd1, 32'h8000_1234, 1'b0, 1'b0, 7'd16);
        wait_tx_end(); wait_done(lag);
        chk("R3 bit31 set passes", cap[39], 1);
        chk("R3 frame with bit31", cap, frame_host(6'd1, 32'h8000_1234));
        issue(6'd1, 32'h0000_5678, 1'b0, 1'b0, 7'd16);
        wait_tx_end(); wait_done(lag);
        chk("R3 bit31 clear passes", cap[39], 0);
    endtask

    task automatic t_overlap();
        int lag;
        issue(6'd2, 32'h0000_00AA, 1'b0, 1'b0, 7'd16);
        repeat (5) @(negedge clk);
        chk("R5 busy during send", busy, 1);
        #1; start = 1'b1; cmd_index = 6'd5; cmd_arg = 32'hFFFF_0000;
        @(negedge clk);
        start = 1'b0;
        wait_tx_end(); wait_done(lag);
        @(negedge clk); #1;
        chk("R5 frame untouched", cap, frame_host(6'd2, 32'h0000_00AA));
        chk("R5 single completion", done_n, 1);
        chk("R5 no second frame", {busy, cmd_oe}, 0);
    endtask

    task automatic t_gaps();
        int lag;
        en_div = 3;
        issue(6'd17, 32'hDEAD_BEEF, 1'b0, 1'b0, 7'd16);
        wait_tx_end(); wait_done(lag);
        chk("R6 frame with enable gaps", cap, frame_host(6'd17, 32'hDEAD_BEEF));
        chk("R6 bit count with gaps", cap_n, 48);
        chk("R6 no change without enable", glitch_n, 0);
        en_div = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_resp(input string tag, input logic [5:0] idx, input logic r3,
                          input logic [47:0] f, input int gap, input logic [6:0] lim,
                          input logic [2:0] exp_flags);
        int lag;
        issue(idx, 32'h0000_01AA, 1'b1, r3, lim);
        wait_tx_end();
        reply(gap, f, 1'b1);
        wait_done(lag);
        chk({tag, " done seen"}, done, 1);
        chk({tag, " index out"}, resp_index, f[45:40]);
        chk({tag, " payload out"}, resp_arg, f[39:8]);
        chk({tag, " flags idx/crc/timeout"}, {idx_err, crc_err, timeout}, exp_flags);
    endtask

    task automatic t_normal();
        logic [47:0] good, badidx, badcrc;
        good   = frame_dev(6'd17, 32'h0000_0120);
        badidx = frame_dev(6'd18, 32'h0000_0120);
        badcrc = good ^ 48'h2;
        t_resp("R8 R9 good echo", 6'd17, 1'b0, good, 3, 7'd16, 3'b000);
        repeat (20) @(negedge clk);
        chk("R12 payload held", resp_arg, 32'h0000_0120);
        chk("R12 busy low while held", busy, 0);
        t_resp("R9 index mismatch", 6'd17, 1'b0, badidx, 0, 7'd16, 3'b100);
        t_no_resp(6'd0, 32'h0, 7'h4A);
        chk("R12 flags cleared by new command", {idx_err, crc_err}, 0);
        t_resp("R9 crc mismatch", 6'd17, 1'b0, badcrc, 1, 7'd16, 3'b010);
        t_resp("R9 bad stop bit", 6'd17, 1'b0, good ^ 48'h1, 1, 7'd16, 3'b010);
        en_div = 2;
        t_resp("R8 good echo with gaps", 6'd17, 1'b0, good, 2, 7'd16, 3'b000);
        en_div = 1;
    endtask

    task automatic t_r3();
        logic [47:0] r3f, realf;
        r3f   = frame_r3(32'h80FF_8080);
        realf = frame_dev(6'd1, 32'h80FF_8080);
        t_resp("R10 ones mode ok", 6'd1, 1'b1, r3f, 2, 7'd16, 3'b000);
        t_resp("R10 ones mode with real fields", 6'd1, 1'b1, realf, 2, 7'd16,
               {1'b1, (realf[7:1] != 7'h7F), 1'b0});
        t_resp("R10 ones frame in normal mode", 6'd1, 1'b0, r3f, 2, 7'd16,
               {1'b1, (crc_b({2'b00, 6'h3F, 32'h80FF_8080}) != 7'h7F), 1'b0});
    endtask

    task automatic t_window();
        int lag;
        t_resp("R11 start on last window sample", 6'd3, 1'b0,
               frame_dev(6'd3, 32'h1234_5678), 4, 7'd5, 3'b000);
        issue(6'd3, 32'h0, 1'b1, 1'b0, 7'd5);
        wait_tx_end();
        reply(5, 48'h0, 1'b0);
        wait_done(lag);
        chk("R11 timeout done seen", done, 1);
        chk("R11 timeout flags", {idx_err, crc_err, timeout}, 3'b001);
        @(negedge clk);
        chk("R11 idle after timeout", busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog (all requirements): actual hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_resp(6'd0, 32'h0, 7'h4A);
        t_no_resp(6'd8, 32'h0000_01AA, 7'h43);
        t_busy_bit();
        t_overlap();
        t_gaps();
        t_normal();
        t_r3();
        t_window();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule